// File: doc/BRIEF.md
# Bidirectional Port with Standby Pin Control

This block is one parallel I/O port of a microcontroller. Each of its pins can be an input or an output. A direction register selects the mode of each pin. An output latch holds the value that the pin drives while it is an output. The CPU reaches both registers over a small single-cycle register bus. Two extra bus addresses set or clear a single latch bit by index, and they touch no other latch bit.

A standby interface supplies a stop flag and a pin-hold select. When both are high, every pin driver is turned off, whatever the direction register holds. The direction register itself is left as it was, so the drivers return one clock after stop ends. Each pin can also select a pull-up. A pin with its pull-up selected and its driver off is seen as high by the read path. Pin levels pass through a two-flop synchroniser before the CPU can read them. Reset clears the direction register, but the output latch keeps its contents.

Top module: `gpio_standby_port`

## Requirements
- R1: A pin whose direction bit is 1 has `padOe` high from the clock edge after the edge that stored that bit. `padOut` always presents the output latch.
- R2: A pin whose direction bit is 0 has `padOe` low from the clock edge after the edge that stored that bit.
- R3: A write to address 1 loads `busWdata` into the output latch on the next edge, whatever the pin directions are. The latched value is driven once a pin is switched to output.
- R4: A read of address 1 returns the pin levels through a two-flop synchroniser. A level applied before edge k is visible on `busRdata` after edge k+1. An output pin reads back its latch bit.
- R5: A write to address 2 sets the latch bit whose index is `busWdata[2:0]`. All other latch bits keep their values, even on input pins whose levels differ.
- R6: A write to address 3 clears the latch bit whose index is `busWdata[2:0]`. All other latch bits keep their values.
- R7: While `rst` is high, the direction register and the synchroniser are cleared and every `padOe` is low. The output latch keeps its value through reset.
- R8: While `stopMode` and `pinHiz` are both high, every `padOe` is low from the next edge onward. The direction register keeps its value, and it reads back unchanged at address 0.
- R9: With `stopMode` high and `pinHiz` low, the pins behave exactly as in normal operation.
- R10: When the forced-off condition ends, `padOe` again follows the direction register from the next clock edge.
- R11: A pin with its `pullSel` bit high and its driver off is read as 1, whatever level `padIn` has.
- R12: Address 0 reads and writes the direction register. Addresses 2 and 3 read as zero. A write is only performed when `busSel` and `busWe` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Bus access select |
| busWe | input | 1 | Write strobe (whole byte) |
| busAddr | input | 2 | 0 direction, 1 data, 2 bit set, 3 bit clear |
| busWdata | input | 8 | Write data, or bit index in bits [2:0] |
| busRdata | output | 8 | Combinational read data |
| stopMode | input | 1 | Device is in stop mode |
| pinHiz | input | 1 | Selects high impedance pins during stop |
| pullSel | input | 8 | Per-pin pull-up select |
| padIn | input | 8 | External level at each pad when not driven by the port |
| padOut | output | 8 | Pin output values |
| padOe | output | 8 | Pin output enables |

## Verification
The bench uses the default width of 8 pins and a two-stage synchroniser. With eight pins, bit indices 0 and 7 can be set and cleared at the two ends of the latch. Input pins can be set to levels that differ from their latch bits, so a read-modify-write that took pin levels by mistake would change the latch and be caught. With two sync stages, the read latency is short enough that the bench model can compare every read on every cycle, including the cycles right after a pad level changes and around reset.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic setBit;
    logic clrBit;
  } strobe_t;

  localparam int unsigned ADDR_DIR = 0;
  localparam int unsigned ADDR_DATA = 1;
  localparam int unsigned ADDR_SET = 2;
  localparam int unsigned ADDR_CLR = 3;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  dirQ,
  input  logic [WIDTH-1:0]  pinQ,
  output strobe_t           strb,
  output logic [WIDTH-1:0]  busRdata
);
  logic wrEn;

  always_comb begin
    wrEn = busSel && busWe;
    strb = '0;
    strb.wrDir  = wrEn && (busAddr == ADDR_W'(ADDR_DIR));
    strb.wrData = wrEn && (busAddr == ADDR_W'(ADDR_DATA));
    strb.setBit = wrEn && (busAddr == ADDR_W'(ADDR_SET));
    strb.clrBit = wrEn && (busAddr == ADDR_W'(ADDR_CLR));
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(ADDR_DIR):  busRdata = dirQ;
      ADDR_W'(ADDR_DATA): busRdata = pinQ;
      default:            busRdata = '0;
    endcase
  end

  // R12: at most one register operation per cycle
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrDir, strb.wrData, strb.setBit, strb.clrBit}));

  // R12: no write operation without a bus write
  a_r12_write_gated: assert property (@(posedge clk) disable iff (rst)
    !(busSel && busWe) |-> (strb == '0));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] busWdata,
  input  logic             stopMode,
  input  logic             pinHiz,
  input  logic [WIDTH-1:0] pullSel,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] pinQ
);
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] latchReg;
  logic [WIDTH-1:0] oeReg;
  logic [WIDTH-1:0] bitMask;
  logic [WIDTH-1:0] padLevel;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];
  logic             forceOff;

  assign forceOff = stopMode && pinHiz;
  assign bitMask  = WIDTH'(1) << busWdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dirReg <= '0;
      oeReg  <= '0;
    end else begin
      oeReg <= forceOff ? '0 : dirReg;
      if (strb.wrDir) dirReg <= busWdata;
    end
  end

  // output latch: no reset, keeps contents across it
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (strb.wrData)      latchReg <= busWdata;
      else if (strb.setBit) latchReg <= latchReg | bitMask;
      else if (strb.clrBit) latchReg <= latchReg & ~bitMask;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_pad
      always_comb begin
        if (oeReg[gi])        padLevel[gi] = latchReg[gi];
        else if (pullSel[gi]) padLevel[gi] = 1'b1;
        else                  padLevel[gi] = padIn[gi];
      end
    end
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncStage[gi] <= '0;
        else if (gi == 0) syncStage[gi] <= padLevel;
        else syncStage[gi] <= syncStage[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign padOut = latchReg;
  assign padOe  = oeReg;
  assign dirQ   = dirReg;
  assign pinQ   = syncStage[SYNC_STAGES-1];

  // R8: stop with pin hold off releases every driver next cycle
  a_r8_forced_off: assert property (@(posedge clk) disable iff (rst)
    forceOff |=> (padOe == '0));

  // R1 / R2 / R10: outside forced-off, enables follow the direction register
  a_r1_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
    !forceOff |=> (padOe == $past(dirReg)));

  // R7: reset leaves direction cleared
  a_r7_dir_cleared: assert property (@(posedge clk)
    rst |=> (dirReg == '0 && padOe == '0));

  // R5: addressed bit is set after a set operation
  a_r5_bit_set: assert property (@(posedge clk) disable iff (rst)
    strb.setBit |=> ((latchReg & $past(bitMask)) == $past(bitMask)));

  // R6: addressed bit is clear after a clear operation
  a_r6_bit_clear: assert property (@(posedge clk) disable iff (rst)
    strb.clrBit |=> ((latchReg & $past(bitMask)) == '0));
endmodule

// File: rtl/gpio_standby_port.sv
module gpio_standby_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic              stopMode,
  input  logic              pinHiz,
  input  logic [WIDTH-1:0]  pullSel,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe
);
  strobe_t          strb;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] pinQ;

  gpio_ctrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .dirQ(dirQ), .pinQ(pinQ), .strb(strb), .busRdata(busRdata)
  );

  gpio_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .busWdata(busWdata),
    .stopMode(stopMode), .pinHiz(pinHiz), .pullSel(pullSel), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .dirQ(dirQ), .pinQ(pinQ)
  );
endmodule

// File: tb/gpio_standby_port_bench.sv
module gpio_standby_port_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] busRdata;
  logic stopMode = 1'b0, pinHiz = 1'b0;
  logic [W-1:0] pullSel = '0, padIn = '0;
  logic [W-1:0] padOut, padOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string phase = "R7";

  // behavioural reference state
  logic [W-1:0] mDir = '0, mLatch = '0, mKnown = '0, mOe = '0;
  logic [W-1:0] mSync[$];

  always #5 clk = ~clk;

  gpio_standby_port u_gpio_standby_port (
    .clk(clk), .rst(rst), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .stopMode(stopMode),
    .pinHiz(pinHiz), .pullSel(pullSel), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  initial begin
    mSync.push_back('0);
    mSync.push_back('0);
  end

  always @(posedge clk) begin
    logic [W-1:0] lvl;
    logic [W-1:0] newOe;
    for (int b = 0; b < W; b++)
      lvl[b] = mOe[b] ? mLatch[b] : (pullSel[b] ? 1'b1 : padIn[b]);
    newOe = (stopMode && pinHiz) ? '0 : mDir;
    if (rst) begin
      mDir = '0; mOe = '0;
      mSync = {};
      mSync.push_back('0); mSync.push_back('0);
    end else begin
      void'(mSync.pop_front());
      mSync.push_back(lvl);
      mOe = newOe;
      if (busSel && busWe) begin
        case (busAddr)
          2'd0: mDir = busWdata;
          2'd1: begin mLatch = busWdata; mKnown = '1; end
          2'd2: mLatch[busWdata[2:0]] = 1'b1;
          default: mLatch[busWdata[2:0]] = 1'b0;
        endcase
      end
    end
  end

  task automatic compare(string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", phase, what, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      compare("padOe", padOe, mOe);
      compare("padOut", padOut & mKnown, mLatch & mKnown);
      case (busAddr)
        2'd0: compare("read dir", busRdata, mDir);
        2'd1: compare("read pins", busRdata, mSync[0]);
        default: compare("read zero", busRdata, '0);
      endcase
    end
  end

  task automatic busWrite(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0; busAddr = 2'd1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    @(negedge clk); rst = 1'b0;
    phase = "R7"; compare("reset oe", padOe, '0);
    phase = "R12"; busAddr = 2'd0; idle(1);
    compare("dir after reset", busRdata, '0);
    busWrite(2'd2, 8'h00); busAddr = 2'd3; idle(1);
    phase = "R3"; padIn = 8'h3C; busWrite(2'd1, 8'hA5); idle(3);
    phase = "R4"; idle(2); padIn = 8'hC3; idle(3);
    phase = "R12"; busSel = 1'b1; busWe = 1'b0; busAddr = 2'd0; busWdata = 8'hFF; idle(2);
    busSel = 1'b0;
    phase = "R1"; busWrite(2'd0, 8'hF0); idle(3);
    phase = "R2"; busWrite(2'd0, 8'h0F); idle(3);
    busWrite(2'd0, 8'hF0); idle(2);
    phase = "R5"; padIn = 8'h0A; busWrite(2'd2, 8'd1); idle(1);
    busWrite(2'd2, 8'd7); busWrite(2'd2, 8'd6); idle(3);
    phase = "R6"; busWrite(2'd3, 8'd0); busWrite(2'd3, 8'd7); busWrite(2'd3, 8'd4); idle(3);
    phase = "R11"; padIn = 8'h00; pullSel = 8'h0F; idle(4);
    pullSel = 8'hFF; idle(4); pullSel = 8'h00; idle(2);
    phase = "R8"; busWrite(2'd1, 8'h5A); stopMode = 1'b1; pinHiz = 1'b1; idle(4);
    busAddr = 2'd0; idle(2);
    phase = "R10"; stopMode = 1'b0; idle(3);
    phase = "R9"; stopMode = 1'b1; pinHiz = 1'b0; busWrite(2'd0, 8'h3C); idle(3);
    stopMode = 1'b0;
    phase = "R8"; pinHiz = 1'b1; idle(2); pinHiz = 1'b0; idle(2);
    phase = "R7"; busWrite(2'd1, 8'h96); rst = 1'b1; idle(3); rst = 1'b0;
    busWrite(2'd0, 8'hFF); idle(3);
    compare("latch kept", padOut, 8'h96);
    compare("all driven", padOe, 8'hFF);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule